// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the device-side command logic of a byte-wide parallel flash. It samples the chip-enable, write-enable and output-enable strobes on a clock. Each new bus write cycle advances a set of command sequences. When a sequence completes, the block issues a one-cycle request for a byte program, a buffered-program byte load, a buffered-program commit, a sector erase or a chip erase. The write address and data go out on a shared pair of buses with the request. The memory array, the program and erase timing and sector protection sit outside this block.

Two level outputs report the current mode. One shows whether reads return the identification register instead of the array. The other shows whether the short two-cycle program path is active. A hardware accelerate input forces the short path for as long as it is held.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write cycle is taken only on the first clock where chip-enable and write-enable are low and output-enable is high. Any other strobe combination leaves the sequence state unchanged.
- R2: The normal byte program is four writes: 0xAA at unlock address 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the target address and data. The fourth write raises `prog_o` for one cycle with that address and data. Unlock addresses compare only the low UNLK_W address bits.
- R3: The two unlock writes followed by 0x20 at 0x555 raise `bypass_o`. In that mode a program is 0xA0 at any address followed by the target write. A write that matches no step in this mode keeps the short path.
- R4: In the short path, data 0x90 followed by data 0x00 clears `bypass_o` and returns to the normal read-array state.
- R5: While `accel_i` is high, `bypass_o` is high and the two-cycle program is accepted. When it drops with no command-entered bypass, any partial sequence is dropped and the block returns to normal idle.
- R6: The two unlock writes followed by 0x90 at 0x555 set `as_mode_o`. The next write of any kind clears it.
- R7: The unlock pair, 0x80 at 0x555, the unlock pair again and 0x10 at 0x555 raise `chip_erase_o` for one cycle.
- R8: The same prefix ending in 0x30 at any address raises `sect_erase_o` with that address. Every further 0x30 write that follows right after marks one more sector.
- R9: The unlock pair, then 0x25, then count N-1, then N byte loads, then 0x29: each load pulses `buf_load_o` with its address and data, and the 0x29 write pulses `buf_commit_o`. N is at most BUF_BYTES.
- R10: A count value above BUF_BYTES-1 aborts to idle and sets `buf_err_o`. The flag is cleared by reset or by the next 0x25 command.
- R11: A byte load whose address lies outside the BUF_BYTES-aligned line of the first load aborts to idle, sets `buf_err_o` and issues no load.
- R12: Outside the short path, a write that is not the expected next step returns the block to idle read-array. A new sequence then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | 8 | Bus write data |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| accel_i | input | 1 | Forces the two-cycle program path |
| prog_o | output | 1 | Byte program request pulse |
| buf_load_o | output | 1 | Buffered byte load pulse |
| buf_commit_o | output | 1 | Buffered program commit pulse |
| buf_err_o | output | 1 | Buffered load abort flag |
| sect_erase_o | output | 1 | Sector erase request pulse |
| chip_erase_o | output | 1 | Chip erase request pulse |
| wr_addr_o | output | ADDR_W | Address qualified by the request pulses |
| wr_data_o | output | 8 | Data qualified by the request pulses |
| as_mode_o | output | 1 | Reads return identification codes |
| bypass_o | output | 1 | Two-cycle program path active |

## Verification
The bench builds the block with a 16-bit address, 11 unlock-compare bits and a 32-byte buffer. With the narrow address, a load in the line next to the first one is quick to produce, and so is an address whose low bits match an unlock address. The 32-byte buffer lets the bench test the count limit exactly at 31 and 32. Accelerate is raised and dropped mid-sequence, so the forced short path and the drop of a partial sequence are both checked against the model.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3, S_EMORE,
    S_AS, S_BCNT, S_BLOAD, S_BCONF, S_BP_IDLE, S_BP_PROG, S_BP_EXIT
  } fcs_state_t;

  localparam logic [7:0] D_UNLK1   = 8'hAA;
  localparam logic [7:0] D_UNLK2   = 8'h55;
  localparam logic [7:0] D_PROG    = 8'hA0;
  localparam logic [7:0] D_BYPASS  = 8'h20;
  localparam logic [7:0] D_IDENT   = 8'h90;
  localparam logic [7:0] D_ERASE   = 8'h80;
  localparam logic [7:0] D_SECT    = 8'h30;
  localparam logic [7:0] D_CHIP    = 8'h10;
  localparam logic [7:0] D_BLOAD   = 8'h25;
  localparam logic [7:0] D_BCONF   = 8'h29;
  localparam logic [7:0] D_BPX2    = 8'h00;
  localparam int unsigned A_UNLK1  = 'h555;
  localparam int unsigned A_UNLK2  = 'h2AA;
endpackage

// File: rtl/fcs_wr_detect.sv
module fcs_wr_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic wr_o
);
  logic act, act_q;
  assign act = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;

  // one event per strobe assertion
  assign wr_o = act & ~act_q;
endmodule

// File: rtl/fcs_buf_track.sv
module fcs_buf_track #(
  parameter int ADDR_W    = 22,
  parameter int BUF_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        cnt_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              last_o,
  output logic              line_ok_o
);
  localparam int LINE_LSB = $clog2(BUF_BYTES);
  localparam int CNT_W    = (LINE_LSB < 1) ? 1 : LINE_LSB;

  logic [CNT_W-1:0]           rem_q;
  logic [ADDR_W-1:LINE_LSB]   line_q;
  logic                       first_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rem_q   <= '0;
      line_q  <= '0;
      first_q <= 1'b0;
    end else if (start_i) begin
      rem_q   <= cnt_i[CNT_W-1:0];
      first_q <= 1'b1;
    end else if (load_i) begin
      if (first_q) line_q <= addr_i[ADDR_W-1:LINE_LSB];
      first_q <= 1'b0;
      rem_q   <= rem_q - 1'b1;
    end

  assign last_o    = (rem_q == '0);
  assign line_ok_o = first_q | (addr_i[ADDR_W-1:LINE_LSB] == line_q);
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int UNLK_W    = 11,
  parameter int BUF_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              accel_i,
  input  logic              last_i,
  input  logic              line_ok_i,
  output logic              buf_start_o,
  output logic              buf_step_o,
  output logic              prog_o,
  output logic              buf_load_o,
  output logic              buf_commit_o,
  output logic              buf_err_o,
  output logic              sect_erase_o,
  output logic              chip_erase_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              as_mode_o,
  output logic              bypass_o
);
  localparam logic [UNLK_W-1:0] UA1 = UNLK_W'(A_UNLK1);
  localparam logic [UNLK_W-1:0] UA2 = UNLK_W'(A_UNLK2);
  localparam logic [7:0]        CNT_MAX = 8'(BUF_BYTES - 1);

  fcs_state_t st_q, st_d, cur;
  logic bp_q, bp_d, eff_bp, in_bp, err_d;
  logic prog_d, load_d, commit_d, sect_d, chip_d;
  logic a1, a2;

  assign a1     = (addr_i[UNLK_W-1:0] == UA1);
  assign a2     = (addr_i[UNLK_W-1:0] == UA2);
  assign eff_bp = bp_q | accel_i;
  assign in_bp  = (st_q == S_BP_IDLE) || (st_q == S_BP_PROG) || (st_q == S_BP_EXIT);

  always_comb begin
    if (eff_bp && !in_bp)      cur = S_BP_IDLE;
    else if (!eff_bp && in_bp) cur = S_IDLE;
    else                       cur = st_q;
  end

  always_comb begin
    st_d = cur; bp_d = bp_q; err_d = buf_err_o;
    prog_d = 1'b0; load_d = 1'b0; commit_d = 1'b0; sect_d = 1'b0; chip_d = 1'b0;
    buf_start_o = 1'b0; buf_step_o = 1'b0;
    if (wr_i) begin
      st_d = S_IDLE;
      unique case (cur)
        S_IDLE: if (a1 && data_i == D_UNLK1) st_d = S_U1;
        S_U1:   if (a2 && data_i == D_UNLK2) st_d = S_U2;
        S_U2: begin
          if (a1 && data_i == D_PROG)        st_d = S_PROG;
          else if (a1 && data_i == D_BYPASS) begin st_d = S_BP_IDLE; bp_d = 1'b1; end
          else if (a1 && data_i == D_IDENT)  st_d = S_AS;
          else if (a1 && data_i == D_ERASE)  st_d = S_E1;
          else if (data_i == D_BLOAD)        begin st_d = S_BCNT; err_d = 1'b0; end
        end
        S_PROG: prog_d = 1'b1;
        S_E1:   if (a1 && data_i == D_UNLK1) st_d = S_E2;
        S_E2:   if (a2 && data_i == D_UNLK2) st_d = S_E3;
        S_E3: begin
          if (a1 && data_i == D_CHIP)   chip_d = 1'b1;
          else if (data_i == D_SECT)    begin sect_d = 1'b1; st_d = S_EMORE; end
        end
        S_EMORE: if (data_i == D_SECT) begin sect_d = 1'b1; st_d = S_EMORE; end
        S_AS:   ;
        S_BCNT: begin
          if (data_i > CNT_MAX) err_d = 1'b1;
          else begin buf_start_o = 1'b1; st_d = S_BLOAD; end
        end
        S_BLOAD: begin
          if (!line_ok_i) err_d = 1'b1;
          else begin
            load_d = 1'b1; buf_step_o = 1'b1;
            st_d = last_i ? S_BCONF : S_BLOAD;
          end
        end
        S_BCONF: if (data_i == D_BCONF) commit_d = 1'b1;
        S_BP_IDLE: begin
          st_d = S_BP_IDLE;
          if (data_i == D_PROG)       st_d = S_BP_PROG;
          else if (data_i == D_IDENT) st_d = S_BP_EXIT;
        end
        S_BP_PROG: begin prog_d = 1'b1; st_d = S_BP_IDLE; end
        S_BP_EXIT: begin
          st_d = S_BP_IDLE;
          if (data_i == D_BPX2) begin
            bp_d = 1'b0;
            st_d = accel_i ? S_BP_IDLE : S_IDLE;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q <= S_IDLE; bp_q <= 1'b0; buf_err_o <= 1'b0;
      prog_o <= 1'b0; buf_load_o <= 1'b0; buf_commit_o <= 1'b0;
      sect_erase_o <= 1'b0; chip_erase_o <= 1'b0;
      wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      st_q <= st_d; bp_q <= bp_d; buf_err_o <= err_d;
      prog_o <= prog_d; buf_load_o <= load_d; buf_commit_o <= commit_d;
      sect_erase_o <= sect_d; chip_erase_o <= chip_d;
      if (wr_i) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end
    end

  assign as_mode_o = (cur == S_AS);
  assign bypass_o  = eff_bp;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W    = 22,
  parameter int UNLK_W    = 11,
  parameter int BUF_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              accel_i,
  output logic              prog_o,
  output logic              buf_load_o,
  output logic              buf_commit_o,
  output logic              buf_err_o,
  output logic              sect_erase_o,
  output logic              chip_erase_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              as_mode_o,
  output logic              bypass_o
);
  logic wr, last, line_ok, buf_start, buf_step;

  fcs_wr_detect u_det (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .wr_o(wr)
  );

  fcs_buf_track #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_trk (
    .clk_i, .rst_ni, .start_i(buf_start), .cnt_i(data_i), .load_i(buf_step),
    .addr_i, .last_o(last), .line_ok_o(line_ok)
  );

  fcs_seq #(.ADDR_W(ADDR_W), .UNLK_W(UNLK_W), .BUF_BYTES(BUF_BYTES)) u_seq (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i, .data_i, .accel_i,
    .last_i(last), .line_ok_i(line_ok),
    .buf_start_o(buf_start), .buf_step_o(buf_step),
    .prog_o, .buf_load_o, .buf_commit_o, .buf_err_o, .sect_erase_o, .chip_erase_o,
    .wr_addr_o, .wr_data_o, .as_mode_o, .bypass_o
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] data_i,
  input logic       ce_ni,
  input logic       we_ni,
  input logic       oe_ni,
  input logic       accel_i,
  input logic       prog_o,
  input logic       buf_load_o,
  input logic       buf_commit_o,
  input logic       buf_err_o,
  input logic       sect_erase_o,
  input logic       chip_erase_o,
  input logic       as_mode_o,
  input logic       bypass_o
);
  logic any_req;
  assign any_req = prog_o | buf_load_o | buf_commit_o | sect_erase_o | chip_erase_o;

  a_r1_req_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |-> $past(!ce_ni && !we_ni && oe_ni));

  a_r12_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_o, buf_load_o, buf_commit_o, sect_erase_o, chip_erase_o}));

  a_r5_accel_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accel_i |-> bypass_o);

  a_r6_modes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_mode_o |-> !bypass_o);

  a_r4_exit_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bypass_o) && !$past(accel_i)) |-> ($past(data_i) == 8'h00));

  a_r10_no_commit_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_err_o) |-> !buf_load_o && !buf_commit_o);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk_i, .rst_ni, .data_i, .ce_ni, .we_ni, .oe_ni, .accel_i,
  .prog_o, .buf_load_o, .buf_commit_o, .buf_err_o, .sect_erase_o, .chip_erase_o,
  .as_mode_o, .bypass_o
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int AW = 16;
  localparam int UW = 11;
  localparam int BB = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, accel = 1'b0;
  logic prog, bload, bcommit, berr, serase, cerase, asm, bp;
  logic [AW-1:0] waddr;
  logic [7:0] wdata;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .UNLK_W(UW), .BUF_BYTES(BB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n), .accel_i(accel),
    .prog_o(prog), .buf_load_o(bload), .buf_commit_o(bcommit), .buf_err_o(berr),
    .sect_erase_o(serase), .chip_erase_o(cerase), .wr_addr_o(waddr), .wr_data_o(wdata),
    .as_mode_o(asm), .bypass_o(bp)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string req = "R0";

  // model state: 0 idle,1 u1,2 u2,3 prog,4 e1,5 e2,6 e3,7 emore,8 ident,
  // 9 count,10 loads,11 confirm,20 short idle,21 short prog,22 short exit
  int st = 0, rem = 0, line = 0;
  bit mbp = 0, first = 0, merr = 0;
  bit e_prog, e_load, e_commit, e_sect, e_chip;
  int e_addr, e_data;

  function automatic void norm();
    bit eff = mbp | accel;
    if (eff && st < 20) st = 20;
    else if (!eff && st >= 20) st = 0;
  endfunction

  function automatic void model(int a, int d);
    bit u1 = ((a & 'h7FF) == 'h555), u2 = ((a & 'h7FF) == 'h2AA);
    int nx = 0;
    norm();
    e_addr = a; e_data = d;
    case (st)
      0: if (u1 && d == 'hAA) nx = 1;
      1: if (u2 && d == 'h55) nx = 2;
      2: if (u1 && d == 'hA0) nx = 3;
         else if (u1 && d == 'h20) begin nx = 20; mbp = 1; end
         else if (u1 && d == 'h90) nx = 8;
         else if (u1 && d == 'h80) nx = 4;
         else if (d == 'h25) begin nx = 9; merr = 0; end
      3: e_prog = 1;
      4: if (u1 && d == 'hAA) nx = 5;
      5: if (u2 && d == 'h55) nx = 6;
      6: if (u1 && d == 'h10) e_chip = 1;
         else if (d == 'h30) begin e_sect = 1; nx = 7; end
      7: if (d == 'h30) begin e_sect = 1; nx = 7; end
      9: if (d > BB - 1) merr = 1;
         else begin rem = d + 1; first = 1; nx = 10; end
      10: if (!first && (a >> 5) != line) merr = 1;
          else begin
            if (first) line = a >> 5;
            first = 0; e_load = 1; rem--;
            nx = (rem == 0) ? 11 : 10;
          end
      11: if (d == 'h29) e_commit = 1;
      20: nx = (d == 'hA0) ? 21 : (d == 'h90) ? 22 : 20;
      21: begin e_prog = 1; nx = 20; end
      22: if (d == 0) begin mbp = 0; nx = accel ? 20 : 0; end else nx = 20;
      default: nx = 0;
    endcase
    st = nx;
  endfunction

  task automatic chk(string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, nm, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    norm();
    chk("prog", prog, e_prog);
    chk("buf_load", bload, e_load);
    chk("buf_commit", bcommit, e_commit);
    chk("sect_erase", serase, e_sect);
    chk("chip_erase", cerase, e_chip);
    chk("buf_err", berr, merr);
    chk("as_mode", asm, st == 8);
    chk("bypass", bp, mbp | accel);
    if (e_prog | e_load | e_commit | e_sect) begin
      chk("wr_addr", waddr, e_addr);
      chk("wr_data", wdata, e_data);
    end
    e_prog = 0; e_load = 0; e_commit = 0; e_sect = 0; e_chip = 0;
  endtask

  task automatic wr(int a, int d);
    addr = AW'(a); data = 8'(d); ce_n = 0; we_n = 0; oe_n = 1;
    model(a, d);
    tick();
    we_n = 1; ce_n = 1;
    tick();
  endtask

  task automatic unlk();
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    e_prog = 0; e_load = 0; e_commit = 0; e_sect = 0; e_chip = 0;
    e_addr = 0; e_data = 0;
    repeat (3) @(negedge clk);
    req = "R12"; tick();                 // reset state
    rst_n = 1; tick();

    // R1: strobe combos without a valid write are ignored mid-sequence
    req = "R1";
    unlk();
    addr = AW'('h555); data = 8'h90; ce_n = 0; we_n = 0; oe_n = 0; tick(); tick();
    oe_n = 1; ce_n = 1; tick();
    ce_n = 1; we_n = 0; tick(); we_n = 1; tick();
    wr('h555, 'hA0); wr('h1234, 'h5A);

    req = "R2"; unlk(); wr('h555, 'hA0); wr('h0042, 'hC3);
    // unlock match uses low bits only
    req = "R2"; wr('hF555, 'hAA); wr('h32AA, 'h55); wr('h0555, 'hA0); wr('hBEEF, 'h11);

    req = "R12"; wr('h555, 'hAA); wr('h2AA, 'h12); wr('h100, 'h77);
    unlk(); wr('h123, 'hA0); wr('h200, 'h33);

    req = "R6"; unlk(); wr('h555, 'h90); tick(); wr('h4000, 'h00); tick();

    req = "R7"; unlk(); wr('h555, 'h80); unlk(); wr('h555, 'h10);
    req = "R8"; unlk(); wr('h555, 'h80); unlk(); wr('h8000, 'h30);
    wr('h9000, 'h30); wr('hA000, 'h30); wr('hB000, 'h44); wr('hC000, 'h30);

    req = "R9"; unlk(); wr('h2000, 'h25); wr('h2000, 3);
    for (int i = 0; i < 4; i++) wr('h2040 + i, 'h10 + i);
    wr('h2000, 'h29);
    req = "R9"; unlk(); wr('h2000, 'h25); wr('h2000, 31);
    for (int i = 0; i < 32; i++) wr('h3000 + i, i);
    wr('h3000, 'h29);

    req = "R10"; unlk(); wr('h2000, 'h25); wr('h2000, 32); wr('h3000, 'h01); tick();
    req = "R11"; unlk(); wr('h2000, 'h25); wr('h2000, 2);
    wr('h0100, 'hAB); wr('h0121, 'hCD); wr('h0101, 'hEF);

    req = "R3"; unlk(); wr('h555, 'h20);
    wr('h777, 'hA0); wr('h0303, 'h9C); wr('h111, 'h55); wr('h0, 'hA0); wr('h0404, 'h01);
    req = "R4"; wr('h0, 'h90); wr('h0, 'h01); wr('h0, 'h90); wr('h0, 'h00);
    wr('h0, 'hA0); wr('h0, 'h55);

    req = "R5"; @(negedge clk); accel = 1; model('h0, 'h00); st = st; tick();
    wr('h0, 'hA0); wr('h0505, 'h5E);
    unlk(); wr('h555, 'h20); wr('h0, 'h90); wr('h0, 'h00); tick();
    wr('h0, 'hA0);
    accel = 0; tick(); tick();
    wr('h0, 'h77);
    unlk(); wr('h555, 'hA0); wr('h0606, 'h66);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule